// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host hands it one read or one write at a time through a valid/ready handshake. The block turns each request into a sequence of chip-select, write-strobe and output-strobe levels on the memory pins. Every interval the memory needs is counted out in clock cycles. The counts are derived at elaboration from nanosecond parameters and the clock period, so the same code meets timing at any clock rate. Each count is the time divided by the period, rounded up, and never less than one cycle.

A read selects the memory with the output strobe low and the write strobe high, then samples the data bus once both the address-to-data and output-strobe-to-data times have passed. It returns the byte with a one-cycle valid pulse. A write keeps the output strobe high throughout and lowers the write strobe. It drives the data bus only after the memory's outputs have had time to release, and ends the write with a single rising edge of the write strobe. Between accesses the memory is deselected, which puts it in standby. After reset, a lockout counter holds the handshake off for the supply settling time.

The data bus is split into drive value, drive enable and input, so the tri-state pad itself is placed at the chip boundary.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low for ceil(T_PWRUP_NS/CLK_NS) cycles (40000 at defaults), with `mem_ce_n` high and `mem_ce` low; `req_ready` then rises.
- R2: Whenever no access is in progress, `req_ready` is high and `mem_ce_n` is high (memory deselected, standby); outside the lockout `mem_ce` is high.
- R3: During a read, `mem_ce_n` is low, `mem_oe_n` is low, `mem_we_n` is high, and `mem_addr` holds the request address unchanged.
- R4: Read data is sampled at the clock edge max(ceil(45/T), ceil(22/T)) cycles after the accepting edge (9 at defaults). `rsp_valid` is then high for exactly one cycle with the sampled byte on `rsp_rdata`.
- R5: A read returns the byte most recently written to the same address.
- R6: During a write, `mem_oe_n` stays high. `mem_we_n` goes low at the accepting edge and rises exactly once. `mem_ce_n` and `mem_addr` stay unchanged from the accepting edge until one cycle after that rise.
- R7: The write strobe stays low for N_WL = max(ceil(35/T), N_REL + ceil(25/T), ceil(45/T) - 1) cycles (9 at defaults). This gives a low pulse of at least 35 ns, address and selection valid for at least 35 ns before the rising edge, and data stable for at least 25 ns before it. `req_ready` returns N_WL + 1 cycles after the accepting edge (10 at defaults).
- R8: `mem_dq_oe` is high only during a write. It rises N_REL = max(ceil(18/T), ceil(18/T)) cycles after the accepting edge, at least 18 ns after both the last output-strobe rise and the write-strobe fall. It falls one cycle after `mem_we_n` rises. It is never high while `mem_oe_n` is low.
- R9: A request is accepted only at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole access. `rsp_valid` follows reads only. Two selections begin at least 45 ns apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 8 | Data bus as seen at the pad |

## Verification
The controller is driven with a seeded random mix of reads and writes over a small address window. This exposes read-after-write, write-after-read and back-to-back same-type sequences; a write right after a read is where bus turnaround errors show. Directed accesses to the lowest and highest addresses, with all-zero and all-one bytes, catch address or data bits lost at the edges. A behavioural memory returns a poison byte until its read-access times have elapsed, so sampling one cycle early gives a wrong byte instead of a lucky match. It also measures every write pulse, setup and release interval in nanoseconds. Latency counts per access confirm the derived cycle counts, and idle gaps confirm the standby deselect.

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 5,
  parameter int T_RC_NS    = 45,
  parameter int T_AA_NS    = 45,
  parameter int T_DOE_NS   = 22,
  parameter int T_WC_NS    = 45,
  parameter int T_PWE_NS   = 35,
  parameter int T_AW_NS    = 35,
  parameter int T_SD_NS    = 25,
  parameter int T_HZOE_NS  = 18,
  parameter int T_HZWE_NS  = 18,
  parameter int T_PWRUP_NS = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_RD  = imax(imax(ns2cyc(T_AA_NS), ns2cyc(T_RC_NS)), ns2cyc(T_DOE_NS));
  localparam int N_REL = imax(ns2cyc(T_HZWE_NS), ns2cyc(T_HZOE_NS));
  localparam int N_WL  = imax(imax(ns2cyc(T_PWE_NS), ns2cyc(T_AW_NS)),
                              imax(N_REL + ns2cyc(T_SD_NS), ns2cyc(T_WC_NS) - 1));
  localparam int N_PWR = ns2cyc(T_PWRUP_NS);
  localparam int N_MAX = imax(N_PWR, imax(N_RD, N_WL));
  localparam int CNT_W = $clog2(N_MAX + 1);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] WL_LAST  = CNT_W'(N_WL - 1);
  localparam logic [CNT_W-1:0] PWR_LAST = CNT_W'(N_PWR - 1);
  localparam logic [CNT_W-1:0] REL_CNT  = CNT_W'(N_REL);

  typedef enum logic [4:0] {
    S_PWR   = 5'b00001,
    S_IDLE  = 5'b00010,
    S_READ  = 5'b00100,
    S_WRITE = 5'b01000,
    S_WREC  = 5'b10000
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_PWR;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      cnt   <= cnt + 1'b1;
      case (state)
        S_PWR: if (cnt == PWR_LAST) begin
          state <= S_IDLE;
          cnt   <= '0;
        end
        S_IDLE: begin
          cnt <= '0;
          if (req_valid) begin
            addr_q <= req_addr;
            if (req_write) begin
              wdata_q <= req_wdata;
              state   <= S_WRITE;
            end else begin
              state <= S_READ;
            end
          end
        end
        S_READ: if (cnt == RD_LAST) begin
          rdata_q <= mem_dq_in;
          rsp_q   <= 1'b1;
          state   <= S_IDLE;
          cnt     <= '0;
        end
        S_WRITE: if (cnt == WL_LAST) begin
          state <= S_WREC;
          cnt   <= '0;
        end
        S_WREC: begin
          state <= S_IDLE;
          cnt   <= '0;
        end
        default: begin
          state <= S_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;
  assign mem_ce     = (state != S_PWR);
  assign mem_ce_n   = !(state inside {S_READ, S_WRITE, S_WREC});
  assign mem_we_n   = (state != S_WRITE);
  assign mem_oe_n   = (state != S_READ);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (state == S_WRITE && cnt >= REL_CNT) || (state == S_WREC);

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W     = 17,
  parameter int CLK_NS     = 5,
  parameter int T_PWE_NS   = 35,
  parameter int T_PWRUP_NS = 200000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int MIN_WE = ns2cyc(T_PWE_NS);
  localparam int N_PWR  = ns2cyc(T_PWRUP_NS);

  int pcnt;
  int we_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt  <= 0;
      we_lo <= 0;
    end else begin
      if (pcnt < N_PWR) pcnt <= pcnt + 1;
      if (!mem_we_n) begin
        if (we_lo < 1000) we_lo <= we_lo + 1;
      end else begin
        we_lo <= 0;
      end
    end
  end

  AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt < N_PWR) |-> (!req_ready && mem_ce_n && !mem_ce)); // R1
  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n); // R2
  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R3
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n)); // R4
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R6
  AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo >= MIN_WE)); // R7
  AST_DRIVE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n)); // R8
  AST_DRIVE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe); // R8
  AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!req_ready)); // R9

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_PWE_NS(T_PWE_NS), .T_PWRUP_NS(T_PWRUP_NS)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + 4) / 5;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int EXP_RD  = (cyc(45) > cyc(22)) ? cyc(45) : cyc(22);
  localparam int EXP_REL = cyc(18);
  localparam int EXP_WL0 = (cyc(35) > EXP_REL + cyc(25)) ? cyc(35) : EXP_REL + cyc(25);
  localparam int EXP_WL  = (EXP_WL0 > cyc(45) - 1) ? EXP_WL0 : cyc(45) - 1;
  localparam int EXP_WR  = EXP_WL + 1;
  localparam int EXP_PWR = cyc(200000);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [16:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  function automatic void chk(input bit ok, input string req, input string what,
                              input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // behavioural memory with interval monitors
  logic [7:0] mdl_mem [int];
  logic [7:0] ref_mem [int];
  realtime t_addr = -1.0e6, t_sel = -1.0e6, t_oe_fall = -1.0e6, t_oe_rise = -1.0e6;
  realtime t_we_fall = -1.0e6, t_dq = -1.0e6;
  wire sel = !mem_ce_n && mem_ce;

  always @(mem_addr) t_addr = $realtime;
  always @(negedge mem_oe_n) t_oe_fall = $realtime;
  always @(posedge mem_oe_n) t_oe_rise = $realtime;
  always @(negedge mem_we_n) t_we_fall = $realtime;
  always @(mem_dq_out) t_dq = $realtime;

  always @(negedge mem_ce_n) begin
    if (rst_n) chk($realtime - t_sel >= 45.0, "R9", "selection spacing ns",
                   int'($realtime - t_sel), 45);
    t_sel = $realtime;
  end

  always @(posedge mem_dq_oe) begin
    if (rst_n) begin
      chk(mem_oe_n, "R8", "drive with oe_n low", int'(mem_oe_n), 1);
      chk($realtime - t_oe_rise >= 18.0 && $realtime - t_we_fall >= 18.0, "R8",
          "release ns before drive", int'($realtime - t_we_fall), 18);
    end
    t_dq = $realtime;
  end

  always @(posedge mem_we_n) begin
    if (rst_n && sel) begin
      chk($realtime - t_we_fall >= 35.0, "R7", "we_n low ns",
          int'($realtime - t_we_fall), 35);
      chk($realtime - t_addr >= 35.0 && $realtime - t_sel >= 35.0, "R7",
          "addr/sel before write end ns", int'($realtime - t_addr), 35);
      chk(mem_dq_oe && $realtime - t_dq >= 25.0, "R7", "data setup ns",
          int'($realtime - t_dq), 25);
      chk(mem_oe_n, "R6", "oe_n during write", int'(mem_oe_n), 1);
      mdl_mem[int'(mem_addr)] = mem_dq_out;
    end
  end

  initial begin
    forever begin
      if (sel && !mem_oe_n && mem_we_n && ($realtime - t_addr >= 44.5) &&
          ($realtime - t_sel >= 44.5) && ($realtime - t_oe_fall >= 21.5))
        mem_dq_in = mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : 8'h00;
      else
        mem_dq_in = 8'hEE;
      #1;
    end
  end

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int lat;
    bit strobes_ok;
    logic [7:0] exp_d;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9", "ready low after accept", int'(req_ready), 0);
    lat = 0;
    strobes_ok = 1'b1;
    if (wr) begin
      ref_mem[int'(a)] = d;
      while (!req_ready && lat < 100) begin
        if (rsp_valid || !mem_oe_n || mem_ce_n || mem_addr != a) strobes_ok = 1'b0;
        @(negedge clk); lat++;
      end
      chk(strobes_ok, "R6", "write strobes/addr held", int'(mem_addr), int'(a));
      chk(lat == EXP_WR, "R7", "write cycles to ready", lat, EXP_WR);
    end else begin
      while (!rsp_valid && lat < 100) begin
        if (mem_oe_n || !mem_we_n || mem_ce_n || mem_addr != a) strobes_ok = 1'b0;
        @(negedge clk); lat++;
      end
      chk(strobes_ok, "R3", "read strobes/addr held", int'(mem_addr), int'(a));
      chk(lat == EXP_RD, "R4", "read latency", lat, EXP_RD);
      exp_d = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
      chk(rsp_rdata == exp_d, "R5", "read data", int'(rsp_rdata), int'(exp_d));
      @(negedge clk);
      chk(!rsp_valid, "R4", "rsp_valid single pulse", int'(rsp_valid), 0);
    end
    chk(req_ready && mem_ce_n && mem_ce, "R2", "idle deselect",
        int'({req_ready, mem_ce_n, mem_ce}), 7);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int k;
    bit lock_ok;
    void'($urandom(32'd4813));
    repeat (3) @(negedge clk);
    chk(!req_ready && mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1", "reset state", int'({req_ready, mem_ce_n, mem_ce, mem_we_n, mem_oe_n}), 5'b01011);
    rst_n = 1'b1;
    k = 0;
    lock_ok = 1'b1;
    // request held during lockout must not be taken
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00010; req_wdata = 8'h77;
    while (!req_ready && k < 50000) begin
      if (!mem_ce_n || mem_ce || !mem_we_n) lock_ok = 1'b0;
      @(negedge clk); k++;
    end
    req_valid = 1'b0;
    chk(lock_ok, "R1", "memory quiet during lockout", int'(mem_ce_n), 1);
    chk(k == EXP_PWR, "R1", "lockout cycles", k, EXP_PWR);
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n, "R9", "no access from lockout request",
        int'(mem_we_n), 1);

    do_op(1'b0, 17'h00010, 8'h00);
    do_op(1'b1, 17'h00000, 8'h5A);
    do_op(1'b1, 17'h1FFFF, 8'hA5);
    do_op(1'b0, 17'h00000, 8'h00);
    do_op(1'b0, 17'h1FFFF, 8'h00);
    do_op(1'b1, 17'h00000, 8'hFF);
    do_op(1'b0, 17'h00000, 8'h00);
    do_op(1'b1, 17'h1FFFF, 8'h00);
    do_op(1'b0, 17'h1FFFF, 8'h00);
    do_op(1'b1, 17'h15555, 8'h3C);
    do_op(1'b0, 17'h15555, 8'h00);
    do_op(1'b1, 17'h0AAAA, 8'hC3);

    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      logic [7:0]  d;
      int sel_a;
      sel_a = int'($urandom_range(0, 9));
      a = (sel_a == 0) ? 17'h1FFFF : (sel_a == 1) ? 17'h00000 : 17'($urandom_range(0, 63));
      d = 8'($urandom);
      if (d == 8'hEE) d = 8'h11;
      do_op(1'($urandom_range(0, 1)), a, d);
      if ($urandom_range(0, 7) == 0) repeat (int'($urandom_range(1, 4))) @(negedge clk);
    end

    lock_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!mem_ce_n || !req_ready || rsp_valid) lock_ok = 1'b0;
    end
    chk(lock_ok, "R2", "standby while idle", int'(mem_ce_n), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule